// File: doc/BRIEF.md
# Serial Conversion Result Port

This block is the digital output stage of a one- or two-channel sampling converter that talks directly to the serial receive port of a signal processor. Each channel hands over its finished conversion as an 18-bit two's-complement word with a one-cycle done strobe. The port keeps the most recent finished word for each channel. It emits that word one convert command late, so the processor always receives the result of the previous sample.

The bit clock is the block's only clock, and the convert command is sampled on it. When the command is seen to fall, each channel's pending word is captured into a holding register. On the following edge the held word goes into an output shift register and a frame sync is raised for one bit period. The word then leaves MSB first, one bit per edge. Bits taken from a per-channel tag input follow directly behind it. A polarity select picks whether the sync is active high or active low. A cascade mode sends the upper 16 bits of channel A and then the upper 16 bits of channel B as one 32-bit word on the channel A output.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is asserted, both serial outputs are 0 and the sync output sits at its inactive level.
- R2: A done strobe stores that channel's result as its pending word. A fall of the convert command (high on one edge, low on the next) copies each pending word into the holding register.
- R3: The sync output is active for exactly one bit-clock period. It starts on the second rising edge after the edge on which the fall was detected, and it never becomes active otherwise.
- R4: In normal mode, the 18 held bits of channel A appear on `sdo_a` MSB first, one per rising edge. The MSB is valid during the sync period.
- R5: The tag bit sampled on the k-th rising edge after the load edge (k ≥ 1) appears on the serial output k−1 bit periods after the frame's last data bit.
- R6: With `sync_hi_sel` = 1 the active sync level is 1. With `sync_hi_sel` = 0 it is 0. The inactive level is the complement.
- R7: Channel B always sends its own 18-bit word and its own tag stream on `sdo_b`, using the same timing as channel A in normal mode.
- R8: With `cascade` = 1, `sdo_a` sends A[17:2] followed by B[17:2] as one 32-bit word. The channel A tag bits follow after bit 32.
- R9: If no done strobe arrives between two convert commands, the previously held word is sent again.
- R10: A new convert command fall during a frame abandons that frame and starts a new one with the usual timing.
- R11: A done strobe in the same cycle as the detected fall is captured directly into the holding register, so its result goes out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv | input | 1 | Convert command; a falling level starts a frame |
| sync_hi_sel | input | 1 | Sync polarity select (1 = active high) |
| cascade | input | 1 | Send both channels' upper halves as one 32-bit word on `sdo_a` |
| done_a | input | 1 | Channel A conversion finished strobe |
| res_a | input | 18 | Channel A conversion result |
| done_b | input | 1 | Channel B conversion finished strobe |
| res_b | input | 18 | Channel B conversion result |
| tag_a | input | 1 | Channel A user tag stream |
| tag_b | input | 1 | Channel B user tag stream |
| sdo_a | output | 1 | Channel A (or cascaded) serial data |
| sdo_b | output | 1 | Channel B serial data |
| sync | output | 1 | Frame sync |

## Verification
Two events can land on the same edge: a channel's done strobe and the detected fall of the convert command. The bench drives `done_a`/`done_b` low-to-high on the exact cycle that `conv` drops. It then expects the fresh result, not the older pending word, in the frame that follows. A separate run without any strobe confirms that the old word repeats. A second overlap is a new fall while a frame is still shifting. In that case the sync position and the new data are compared against a frame that starts from scratch.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W  = 18,
  parameter int HALF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv,
  input  logic             sync_hi_sel,
  input  logic             cascade,
  input  logic             done_a,
  input  logic [RES_W-1:0] res_a,
  input  logic             done_b,
  input  logic [RES_W-1:0] res_b,
  input  logic             tag_a,
  input  logic             tag_b,
  output logic             sdo_a,
  output logic             sdo_b,
  output logic             sync
);
  localparam int FW  = 2 * HALF_W;
  localparam int TAP = FW - RES_W;

  logic             conv_d, load_q, sync_act;
  logic [RES_W-1:0] pend_a, pend_b, hold_a, hold_b;
  logic [FW-1:0]    sh_a, ld_a, nxt_a;
  logic [RES_W-1:0] sh_b;
  logic             fall;

  assign fall = conv_d & ~conv;

  always_comb begin
    ld_a = '0;
    ld_a[FW-1 -: RES_W] = hold_a;
    if (cascade) ld_a = {hold_a[RES_W-1 -: HALF_W], hold_b[RES_W-1 -: HALF_W]};
    nxt_a = {sh_a[FW-2:0], 1'b0};
    if (cascade) nxt_a[0] = tag_a;
    else         nxt_a[TAP] = tag_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_d   <= 1'b0;
      load_q   <= 1'b0;
      sync_act <= 1'b0;
      pend_a   <= '0;
      pend_b   <= '0;
      hold_a   <= '0;
      hold_b   <= '0;
      sh_a     <= '0;
      sh_b     <= '0;
    end else begin
      conv_d   <= conv;
      load_q   <= fall;
      sync_act <= load_q;
      if (done_a) pend_a <= res_a;
      if (done_b) pend_b <= res_b;
      if (fall) begin
        hold_a <= done_a ? res_a : pend_a;
        hold_b <= done_b ? res_b : pend_b;
      end
      sh_a <= load_q ? ld_a : nxt_a;
      sh_b <= load_q ? hold_b : {sh_b[RES_W-2:0], tag_b};
    end
  end

  assign sdo_a = sh_a[FW-1];
  assign sdo_b = sh_b[RES_W-1];
  assign sync  = ~(sync_act ^ sync_hi_sel);
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int RES_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv,
  input logic             sync_hi_sel,
  input logic             done_b,
  input logic [RES_W-1:0] res_b,
  input logic             sdo_b,
  input logic             sync
);
  logic conv_q, fall_w, act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) conv_q <= 1'b0;
    else        conv_q <= conv;

  assign fall_w = conv_q & ~conv;
  assign act    = (sync == sync_hi_sel);

  // R3
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> !act);

  // R3
  sync_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> ##1 act);

  // R3
  sync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> $past(fall_w, 2));

  // R11
  coincide_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_w && done_b) |=> ##1 (sdo_b == $past(res_b[RES_W-1], 2)));
endmodule

bind adc_serial_port adc_serial_port_chk #(.RES_W(RES_W)) u_chk (.*);

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic conv = 1'b1, sync_hi_sel = 1'b1, cascade = 1'b0;
  logic done_a = 1'b0, done_b = 1'b0, tag_a = 1'b0, tag_b = 1'b0;
  logic [17:0] res_a = '0, res_b = '0;
  logic sdo_a, sdo_b, sync;
  logic [17:0] pa = '0, pb = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_serial_port u0 (.clk, .rst_n, .conv, .sync_hi_sel, .cascade, .done_a, .res_a,
                      .done_b, .res_b, .tag_a, .tag_b, .sdo_a, .sdo_b, .sync);

  // ra, rb, tag_a pattern, tag_b pattern, cascade, sync_hi_sel
  localparam logic [69:0] VEC [0:5] = '{
    {18'h2A5F3, 18'h15A0C, 16'hB00F, 16'h4C3A, 1'b0, 1'b1},
    {18'h3FFFF, 18'h00000, 16'h00FF, 16'hFF00, 1'b0, 1'b0},
    {18'h20000, 18'h1FFFF, 16'h5555, 16'hAAAA, 1'b0, 1'b1},
    {18'h3C3C1, 18'h0F0F2, 16'h9E21, 16'h1234, 1'b1, 1'b1},
    {18'h12345, 18'h2BCDE, 16'hFFFF, 16'h0001, 1'b1, 1'b0},
    {18'h00003, 18'h3FFFC, 16'h0F0F, 16'hF0F0, 1'b0, 1'b0}
  };

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // mode 0: no done, 1: done before the command, 2: done with the fall
  task automatic frame(string lbl, int mode, logic [17:0] ra, logic [17:0] rb,
                       logic [15:0] ta, logic [15:0] tb, logic casc, logic sel, int len);
    logic ea, eb;
    int fa;
    @(negedge clk);
    cascade = casc; sync_hi_sel = sel;
    if (mode != 0) begin res_a = ra; res_b = rb; end
    if (mode == 1) begin
      done_a = 1; done_b = 1;
      @(negedge clk);
      done_a = 0; done_b = 0;
    end
    conv = 0;
    if (mode == 2) begin done_a = 1; done_b = 1; end
    if (mode != 0) begin pa = ra; pb = rb; end
    @(negedge clk);
    done_a = 0; done_b = 0; conv = 1;
    @(negedge clk);
    fa = casc ? 32 : 18;
    for (int i = 0; i < len; i++) begin
      if (i < fa) begin
        if (casc) ea = (i < 16) ? pa[17-i] : pb[17-(i-16)];
        else      ea = pa[17-i];
      end else ea = ta[(i-fa) % 16];
      eb = (i < 18) ? pb[17-i] : tb[(i-18) % 16];
      chk({lbl, (i < fa) ? (casc ? " R8 data_a" : " R2 R4 data_a") : " R5 tag_a"}, sdo_a, ea);
      chk({lbl, (i < 18) ? " R7 data_b" : " R5 R7 tag_b"}, sdo_b, eb);
      chk({lbl, " R3 R6 sync"}, sync, (i == 0) ? sel : ~sel);
      tag_a = ta[i % 16];
      tag_b = tb[i % 16];
      if (i != len - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sdo_a", sdo_a, 1'b0);
    chk("R1 sdo_b", sdo_b, 1'b0);
    chk("R1 R6 sync high sel", sync, 1'b0);
    sync_hi_sel = 0;
    @(negedge clk);
    chk("R1 R6 sync low sel", sync, 1'b1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    foreach (VEC[k]) begin
      logic [69:0] v;
      v = VEC[k];
      frame("vec", 1, v[69:52], v[51:34], v[33:18], v[17:2], v[1], v[0],
            v[1] ? 40 : 26);
    end

    frame("R9 repeat", 0, '0, '0, 16'h3C5A, 16'hC3A5, 1'b0, 1'b1, 26);
    frame("R11 coincide", 2, 18'h1E1E1, 18'h2D2D2, 16'h7777, 16'h1111, 1'b0, 1'b1, 26);
    frame("R10 first", 1, 18'h3AAAA, 18'h05555, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 5);
    frame("R10 restart", 1, 18'h0ABCD, 18'h31234, 16'h6B6B, 16'hD4D4, 1'b0, 1'b0, 26);
    frame("R11 cascade coincide", 2, 18'h2FEDC, 18'h10123, 16'hA5A5, 16'h5A5A, 1'b1, 1'b1, 40);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule